// File: doc/BRIEF.md
# Two-Entry Result Bypass Unit

This block forwards operands in a short in-order pipeline. It keeps a history of the last two results that left the execute stage, counting ALU results and loaded values alike. For each result it holds the destination register number and the value. Decode reads both source operands from the register file before it knows whether those values are current. In the same cycle this unit compares the two source register numbers against its history and against any result being written back right now. When a newer value exists, it replaces the register file value, so a dependent instruction can follow its producer with no stall.

The history is a two-slot shift structure with a younger and an older slot. A cycle with a valid result moves the younger entry into the older slot and writes the new result into the younger slot. Stores, branches and squashed instructions simply do not raise the result flag. A flush empties the history. The register file itself and stalls for other resources are outside this block.

Top module: `result_bypass`

## Requirements
- R1: After reset neither history slot is valid, so each operand output equals its register file input until a result arrives.
- R2: When `resValid` is high and `resDest` equals a nonzero source register number, that operand output equals `resValue` in the same cycle.
- R3: A result presented with `resValid` high and `flush` low is stored at the next rising edge. From the next cycle on it is forwarded to any port whose source register number matches its destination.
- R4: The history holds exactly two results. A third stored result evicts the oldest, and from then on a lookup of the evicted destination returns the register file data, unless a remaining entry matches it.
- R5: When both stored entries match the same source register, the operand is taken from the more recently stored entry.
- R6: Source register number 0 is never forwarded. Its operand always equals the register file input, even when a live or stored result targets register 0.
- R7: `flush` high at a rising edge invalidates both history entries, and a result presented in that same cycle is not stored. Lookups during the flush cycle itself behave as in any other cycle.
- R8: The two read ports are looked up independently, and one entry may feed both ports in the same cycle.
- R9: A cycle with `resValid` low leaves the history unchanged.
- R10: A live result on the write-back inputs takes priority over both stored entries for the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Invalidates the history at the next edge |
| srcRegA | input | REG_W | Source register number, port A |
| rfDataA | input | DATA_W | Register file data read for port A |
| srcRegB | input | REG_W | Source register number, port B |
| rfDataB | input | DATA_W | Register file data read for port B |
| resValid | input | 1 | A result is being written back this cycle |
| resDest | input | REG_W | Destination register of the result |
| resValue | input | DATA_W | Value of the result |
| opA | output | DATA_W | Forwarded operand, port A |
| opB | output | DATA_W | Forwarded operand, port B |

## Verification
The bench targets four orderings. When both slots hold the same register, a design that ignores age returns the stale value. When a third result arrives, the evicted register must fall back to the register file; a design that keeps three entries, or that shifts the wrong way, returns an outdated value. Register 0 is exercised with both live and stored results, which catches a design that forwards writes to the hard-wired zero register. Flush cycles that also carry a result catch a design that stores the squashed result. A randomized stretch with a small register range produces frequent collisions between the two ports, the live result and both slots.

// File: rtl/bypass_pkg.sv
package bypass_pkg;

  // Operand source chosen for one read port
  typedef enum logic [1:0] {
    SEL_RF    = 2'd0,
    SEL_LIVE  = 2'd1,
    SEL_YOUNG = 2'd2,
    SEL_OLD   = 2'd3
  } srcSel_e;

  // Strobes from control to the history datapath
  typedef struct packed {
    logic shiftIn;   // push the live result into the younger slot
    logic clearAll;  // drop both valid bits
  } histStrobe_t;

endpackage

// File: rtl/bypass_ctrl.sv
module bypass_ctrl
  import bypass_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int NUM_RD = 2
) (
  input  logic                         resValid,
  input  logic                         flush,
  input  logic [REG_W-1:0]             resDest,
  input  logic [NUM_RD-1:0][REG_W-1:0] srcReg,
  input  logic                         youngValid,
  input  logic [REG_W-1:0]             youngDest,
  input  logic                         oldValid,
  input  logic [REG_W-1:0]             oldDest,
  output histStrobe_t                  strobe,
  output srcSel_e                      sel [NUM_RD]
);

  localparam logic [REG_W-1:0] ZERO_REG = '0;

  // History update: a flush wins over an insertion in the same cycle
  always_comb begin
    strobe.clearAll = flush;
    strobe.shiftIn  = resValid && !flush;
  end

  // Per-port priority: live result, then younger slot, then older slot
  for (genvar p = 0; p < NUM_RD; p++) begin : g_port
    logic isZero, hitLive, hitYoung, hitOld;
    always_comb begin
      isZero   = (srcReg[p] == ZERO_REG);
      hitLive  = resValid   && (resDest   == srcReg[p]);
      hitYoung = youngValid && (youngDest == srcReg[p]);
      hitOld   = oldValid   && (oldDest   == srcReg[p]);
      if (isZero)        sel[p] = SEL_RF;
      else if (hitLive)  sel[p] = SEL_LIVE;
      else if (hitYoung) sel[p] = SEL_YOUNG;
      else if (hitOld)   sel[p] = SEL_OLD;
      else               sel[p] = SEL_RF;
    end
  end

endmodule

// File: rtl/bypass_data.sv
module bypass_data
  import bypass_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  parameter int NUM_RD = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  histStrobe_t                   strobe,
  input  logic [REG_W-1:0]              resDest,
  input  logic [DATA_W-1:0]             resValue,
  input  srcSel_e                       sel [NUM_RD],
  input  logic [NUM_RD-1:0][DATA_W-1:0] rfData,
  output logic [NUM_RD-1:0][DATA_W-1:0] opOut,
  output logic                          youngValid,
  output logic [REG_W-1:0]              youngDest,
  output logic                          oldValid,
  output logic [REG_W-1:0]              oldDest
);

  logic [DATA_W-1:0] youngValue, oldValue;

  // Valid bits: cleared by reset or flush, shifted on insertion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      youngValid <= 1'b0;
      oldValid   <= 1'b0;
    end else if (strobe.clearAll) begin
      youngValid <= 1'b0;
      oldValid   <= 1'b0;
    end else if (strobe.shiftIn) begin
      oldValid   <= youngValid;
      youngValid <= 1'b1;
    end
  end

  // Tags and values carry no reset: they are qualified by the valid bits
  always_ff @(posedge clk) begin
    if (strobe.shiftIn) begin
      oldDest    <= youngDest;
      oldValue   <= youngValue;
      youngDest  <= resDest;
      youngValue <= resValue;
    end
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_mux
    always_comb begin
      unique case (sel[p])
        SEL_LIVE:  opOut[p] = resValue;
        SEL_YOUNG: opOut[p] = youngValue;
        SEL_OLD:   opOut[p] = oldValue;
        default:   opOut[p] = rfData[p];
      endcase
    end
  end

endmodule

// File: rtl/result_bypass.sv
module result_bypass
  import bypass_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [REG_W-1:0]  srcRegA,
  input  logic [DATA_W-1:0] rfDataA,
  input  logic [REG_W-1:0]  srcRegB,
  input  logic [DATA_W-1:0] rfDataB,
  input  logic              resValid,
  input  logic [REG_W-1:0]  resDest,
  input  logic [DATA_W-1:0] resValue,
  output logic [DATA_W-1:0] opA,
  output logic [DATA_W-1:0] opB
);

  localparam int NUM_RD = 2;

  histStrobe_t                   strobe;
  srcSel_e                       sel [NUM_RD];
  logic [NUM_RD-1:0][REG_W-1:0]  srcReg;
  logic [NUM_RD-1:0][DATA_W-1:0] rfData, opOut;
  logic                          youngValid, oldValid;
  logic [REG_W-1:0]              youngDest, oldDest;

  assign srcReg = {srcRegB, srcRegA};
  assign rfData = {rfDataB, rfDataA};
  assign opA    = opOut[0];
  assign opB    = opOut[1];

  bypass_ctrl #(.REG_W(REG_W), .NUM_RD(NUM_RD)) u_ctrl (
    .resValid  (resValid),
    .flush     (flush),
    .resDest   (resDest),
    .srcReg    (srcReg),
    .youngValid(youngValid),
    .youngDest (youngDest),
    .oldValid  (oldValid),
    .oldDest   (oldDest),
    .strobe    (strobe),
    .sel       (sel)
  );

  bypass_data #(.DATA_W(DATA_W), .REG_W(REG_W), .NUM_RD(NUM_RD)) u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .resDest   (resDest),
    .resValue  (resValue),
    .sel       (sel),
    .rfData    (rfData),
    .opOut     (opOut),
    .youngValid(youngValid),
    .youngDest (youngDest),
    .oldValid  (oldValid),
    .oldDest   (oldDest)
  );

endmodule

// File: rtl/result_bypass_chk.sv
module result_bypass_chk #(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic [REG_W-1:0]  srcRegA,
  input logic [DATA_W-1:0] rfDataA,
  input logic [REG_W-1:0]  srcRegB,
  input logic [DATA_W-1:0] rfDataB,
  input logic              resValid,
  input logic [REG_W-1:0]  resDest,
  input logic [DATA_W-1:0] resValue,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB
);

  assert_zero_reg_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (srcRegA == '0) |-> (opA == rfDataA));

  assert_zero_reg_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (srcRegB == '0) |-> (opB == rfDataB));

  assert_live_fwd_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (resValid && resDest == srcRegA && srcRegA != '0) |-> (opA == resValue));

  assert_live_fwd_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (resValid && resDest == srcRegB && srcRegB != '0) |-> (opB == resValue));

  // A stored result is the youngest entry the following cycle
  assert_stored_fwd_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (resValid && !flush) |=>
      (srcRegA == '0 || srcRegA != $past(resDest) ||
       (resValid && resDest == srcRegA) || opA == $past(resValue)));

  // After a flush only a live result may override the register file
  assert_flush_empty_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ((resValid && resDest == srcRegA && srcRegA != '0) || opA == rfDataA));

  assert_flush_empty_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ((resValid && resDest == srcRegB && srcRegB != '0) || opB == rfDataB));

endmodule

bind result_bypass result_bypass_chk #(.DATA_W(DATA_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush),
  .srcRegA(srcRegA), .rfDataA(rfDataA), .srcRegB(srcRegB), .rfDataB(rfDataB),
  .resValid(resValid), .resDest(resDest), .resValue(resValue),
  .opA(opA), .opB(opB)
);

// File: tb/result_bypass_test.sv
module result_bypass_test;

  localparam int DATA_W = 32;
  localparam int REG_W  = 5;

  typedef struct {
    logic [DATA_W-1:0] expA, expB, gotA, gotB;
    string             tag;
  } item_t;

  logic              clk = 1'b0, rst_n = 1'b0, flush = 1'b0, resValid = 1'b0;
  logic [REG_W-1:0]  srcRegA = '0, srcRegB = '0, resDest = '0;
  logic [DATA_W-1:0] rfDataA = '0, rfDataB = '0, resValue = '0;
  logic [DATA_W-1:0] opA, opB;

  int nChecks = 0, nFail = 0;
  item_t expQ[$];

  // Independent model of the history: index 0 is the younger slot
  logic              mValid [2];
  logic [REG_W-1:0]  mDest  [2];
  logic [DATA_W-1:0] mValue [2];

  always #5 clk = ~clk;

  result_bypass #(.DATA_W(DATA_W), .REG_W(REG_W)) uut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .srcRegA(srcRegA), .rfDataA(rfDataA), .srcRegB(srcRegB), .rfDataB(rfDataB),
    .resValid(resValid), .resDest(resDest), .resValue(resValue),
    .opA(opA), .opB(opB)
  );

  function automatic logic [DATA_W-1:0] model(input logic [REG_W-1:0] src,
                                              input logic [DATA_W-1:0] rf);
    if (src == '0)                         return rf;
    if (resValid && resDest == src)        return resValue;
    if (mValid[0] && mDest[0] == src)      return mValue[0];
    if (mValid[1] && mDest[1] == src)      return mValue[1];
    return rf;
  endfunction

  // Driver: apply one cycle of stimulus, queue the expectation, advance the model
  task automatic step(input logic [REG_W-1:0] sa, input logic [REG_W-1:0] sb,
                      input logic rv, input logic [REG_W-1:0] rd,
                      input logic [DATA_W-1:0] val, input logic fl, input string tag);
    item_t it;
    @(negedge clk);
    srcRegA = sa; srcRegB = sb;
    rfDataA = 32'hA000_0000 | 32'(sa); rfDataB = 32'hB000_0000 | 32'(sb);
    resValid = rv; resDest = rd; resValue = val; flush = fl;
    #2;
    it.expA = model(sa, rfDataA);
    it.expB = model(sb, rfDataB);
    it.gotA = opA; it.gotB = opB;
    it.tag  = tag;
    expQ.push_back(it);
    if (fl) begin
      mValid[0] = 1'b0; mValid[1] = 1'b0;
    end else if (rv) begin
      mValid[1] = mValid[0]; mDest[1] = mDest[0]; mValue[1] = mValue[0];
      mValid[0] = 1'b1; mDest[0] = rd; mValue[0] = val;
    end
  endtask

  // Monitor: pop and compare each captured cycle
  initial begin
    item_t it;
    forever begin
      wait (expQ.size() > 0);
      it = expQ.pop_front();
      nChecks += 2;
      if (it.gotA !== it.expA) begin
        nFail++;
        $display("FAIL %s port A: got %h expected %h", it.tag, it.gotA, it.expA);
      end
      if (it.gotB !== it.expB) begin
        nFail++;
        $display("FAIL %s port B: got %h expected %h", it.tag, it.gotB, it.expB);
      end
    end
  end

  task automatic finish_run();
    #1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  // Watchdog
  initial begin
    #1_000_000;
    nChecks++; nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    mValid[0] = 1'b0; mValid[1] = 1'b0;
    mDest[0] = '0; mDest[1] = '0; mValue[0] = '0; mValue[1] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: empty after reset
    step(5'd3, 5'd4, 1'b0, 5'd0, 0, 1'b0, "R1");
    // R2: live result forwarded in the same cycle
    step(5'd5, 5'd6, 1'b1, 5'd5, 32'h1111_0005, 1'b0, "R2");
    // R3: stored result forwarded next cycle; R8: both ports same entry
    step(5'd5, 5'd5, 1'b0, 5'd0, 0, 1'b0, "R3");
    step(5'd5, 5'd5, 1'b0, 5'd0, 0, 1'b0, "R8");
    // R9: idle cycles keep the history
    step(5'd7, 5'd8, 1'b0, 5'd0, 0, 1'b0, "R9");
    step(5'd5, 5'd2, 1'b0, 5'd0, 0, 1'b0, "R9");
    // R4: three results, the first is evicted
    step(5'd0, 5'd0, 1'b1, 5'd1, 32'h2222_0001, 1'b0, "R4");
    step(5'd0, 5'd0, 1'b1, 5'd2, 32'h2222_0002, 1'b0, "R4");
    step(5'd0, 5'd0, 1'b1, 5'd3, 32'h2222_0003, 1'b0, "R4");
    step(5'd1, 5'd2, 1'b0, 5'd0, 0, 1'b0, "R4");
    step(5'd3, 5'd1, 1'b0, 5'd0, 0, 1'b0, "R4");
    // R5: same register in both slots, younger wins
    step(5'd0, 5'd0, 1'b1, 5'd7, 32'h3333_0A0A, 1'b0, "R5");
    step(5'd7, 5'd0, 1'b1, 5'd7, 32'h3333_0B0B, 1'b0, "R10");
    step(5'd7, 5'd7, 1'b0, 5'd0, 0, 1'b0, "R5");
    // R10: live result beats both stored entries
    step(5'd7, 5'd3, 1'b1, 5'd7, 32'h3333_0C0C, 1'b0, "R10");
    // R6: register 0 never forwarded, live or stored
    step(5'd0, 5'd7, 1'b1, 5'd0, 32'h4444_0000, 1'b0, "R6");
    step(5'd0, 5'd0, 1'b0, 5'd0, 0, 1'b0, "R6");
    // R7: flush with a result in the same cycle stores nothing
    step(5'd7, 5'd9, 1'b1, 5'd9, 32'h5555_0009, 1'b1, "R7");
    step(5'd9, 5'd7, 1'b0, 5'd0, 0, 1'b0, "R7");
    step(5'd0, 5'd0, 1'b1, 5'd9, 32'h5555_1009, 1'b0, "R7");
    step(5'd9, 5'd9, 1'b0, 5'd0, 0, 1'b0, "R3");
    // R8: randomized collisions across ports, live result and slots
    for (int i = 0; i < 400; i++) begin
      step(5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
           1'($urandom_range(0, 1)), 5'($urandom_range(0, 3)), $urandom(),
           ($urandom_range(0, 15) == 0), "R8");
    end
    @(negedge clk);
    wait (expQ.size() == 0);
    finish_run();
  end

endmodule